// File: doc/BRIEF.md
# Power-Stage Overload Supervisor

This block guards an output power stage against two faults: an over-temperature condition and an over-current condition. It receives the junction temperature as an unsigned code in whole degrees Celsius and a raw current-overload comparator level. From the temperature it drives a power-stage disable with a hysteresis band. Thermal protection always acts and does not depend on any host setting.

Each fault source has a sticky flag that the host enables individually. A flag only latches while its enable bit is set. Once set, it stays set after the fault has gone until the host clears it. An active-low interrupt output is pulled low whenever a flag is set and its enable is also set.

The host reaches two registers through a single-cycle synchronous port. One is the control register, which holds the enables. The other is the status register, which holds the flags; the host clears a flag by writing 0 to its bit. Reads are combinational from the registered state.

Top module: `ovld_supervisor`

## Requirements
- R1: `pa_disable` goes high on the first rising clock edge at which `temp_code` is strictly above 165.
- R2: Once high, `pa_disable` stays high while `temp_code` is above 145. It drops on the first rising edge at which `temp_code` is 145 or less.
- R3: The shutdown and release of R1 and R2 behave the same whatever the control enable bits hold.
- R4: The thermal flag is status bit 5. On every edge at which the over-temperature condition of R1/R2 holds and control bit 5 is 1, the flag is set. With control bit 5 at 0, the flag keeps its previous value.
- R5: A set flag stays 1 after its fault has gone, until the host clears it.
- R6: `irq_n` is 0 exactly while (status bit 5 and control bit 5) or (status bit 6 and control bit 6) are both 1. Otherwise it is 1.
- R7: A write with `reg_sel`=1 clears each flag whose bit in `reg_wdata` is 0. A 1 in that bit has no effect. When a set condition and a clear fall on the same edge, the flag ends up 1.
- R8: After reset, `pa_disable` is 0 and `irq_n` is 1. Both flags and control bits 7..5 read 0.
- R9: `ocp_in` passes through a two-flop synchronizer. A 0-to-1 transition sets the current flag (status bit 6) on the third rising edge after the change, if control bit 6 is 1. A level held high sets the flag only once.
- R10: With `reg_sel`=0, `reg_rdata` returns the last value written to control bits 7..5 and zeros elsewhere. With `reg_sel`=1, it returns the flags in bits 6 and 5 and zeros elsewhere. Writes with `reg_sel`=0 load bits 7..5 of `reg_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| temp_code | input | 8 | Junction temperature, unsigned whole degrees Celsius |
| ocp_in | input | 1 | Asynchronous current-overload comparator level |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_sel | input | 1 | Register select: 0 control, 1 status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| pa_disable | output | 1 | Power-stage disable, active high |
| irq_n | output | 1 | Interrupt, active low |

## Verification
A temperature change shows on `pa_disable` and on the thermal flag one edge later. The bench applies each code just after a falling edge and samples at the following falling edge. A change on `ocp_in` reaches the current flag three edges later, and the bench samples one edge before that point and then at it. Register writes take effect on the next edge. `reg_rdata` and `irq_n` follow the registered state without delay, so they are read a short settle time after the `reg_sel` change inside the low clock phase. The same-edge set/clear cases line up the write strobe with the exact edge at which the set condition is first present.

// File: rtl/ovld_pkg.sv
package ovld_pkg;
    localparam int REG_W    = 8;
    localparam int BIT_TEN  = 5;   // control: thermal reporting enable
    localparam int BIT_CEN  = 6;   // control: current reporting enable
    localparam int BIT_RSV  = 7;   // control: reserved, stored only
    localparam int BIT_TFLG = 5;   // status: thermal flag
    localparam int BIT_CFLG = 6;   // status: current flag

    typedef struct packed {
        logic en_t;
        logic en_c;
        logic rsv;
        logic tflag;
        logic cflag;
    } ovld_state_t;
endpackage

// File: rtl/ovld_sync.sv
module ovld_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = d;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], d};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/ovld_edge.sv
module ovld_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise
);
    logic prev_d, prev_q;

    always_comb prev_d = lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    assign rise = lvl & ~prev_q;
endmodule

// File: rtl/ovld_thermal.sv
module ovld_thermal #(
    parameter int TEMP_W  = 8,
    parameter int TRIP_HI = 165,
    parameter int TRIP_LO = 145
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TEMP_W-1:0] temp,
    output logic              hot_d,
    output logic              hot_q
);
    localparam logic [TEMP_W-1:0] HI_C = TEMP_W'(TRIP_HI);
    localparam logic [TEMP_W-1:0] LO_C = TEMP_W'(TRIP_LO);

    always_comb begin
        hot_d = hot_q;
        if (temp > HI_C)       hot_d = 1'b1;
        else if (temp <= LO_C) hot_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hot_q <= 1'b0;
        else        hot_q <= hot_d;
    end
endmodule

// File: rtl/ovld_supervisor.sv
module ovld_supervisor
    import ovld_pkg::*;
#(
    parameter int TEMP_W      = 8,
    parameter int TRIP_HI     = 165,
    parameter int TRIP_LO     = 145,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TEMP_W-1:0] temp_code,
    input  logic              ocp_in,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              pa_disable,
    output logic              irq_n
);
    ovld_state_t cur_q, nxt_d;
    logic hot_d, hot_q;
    logic ocp_sync, ocp_rise;
    logic en_t, en_c, rsv, tflag, cflag;

    ovld_thermal #(.TEMP_W(TEMP_W), .TRIP_HI(TRIP_HI), .TRIP_LO(TRIP_LO)) i_therm (
        .clk(clk), .rst_n(rst_n), .temp(temp_code), .hot_d(hot_d), .hot_q(hot_q)
    );

    ovld_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .d(ocp_in), .q(ocp_sync)
    );

    ovld_edge i_edge (
        .clk(clk), .rst_n(rst_n), .lvl(ocp_sync), .rise(ocp_rise)
    );

    always_comb begin
        nxt_d = cur_q;
        if (reg_wr && !reg_sel) begin
            nxt_d.en_t = reg_wdata[BIT_TEN];
            nxt_d.en_c = reg_wdata[BIT_CEN];
            nxt_d.rsv  = reg_wdata[BIT_RSV];
        end
        if (reg_wr && reg_sel) begin
            if (!reg_wdata[BIT_TFLG]) nxt_d.tflag = 1'b0;
            if (!reg_wdata[BIT_CFLG]) nxt_d.cflag = 1'b0;
        end
        // set after clear: a coincident set condition wins
        if (hot_d && cur_q.en_t)    nxt_d.tflag = 1'b1;
        if (ocp_rise && cur_q.en_c) nxt_d.cflag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign en_t  = cur_q.en_t;
    assign en_c  = cur_q.en_c;
    assign rsv   = cur_q.rsv;
    assign tflag = cur_q.tflag;
    assign cflag = cur_q.cflag;

    always_comb begin
        reg_rdata = '0;
        if (reg_sel) begin
            reg_rdata[BIT_TFLG] = tflag;
            reg_rdata[BIT_CFLG] = cflag;
        end else begin
            reg_rdata[BIT_TEN] = en_t;
            reg_rdata[BIT_CEN] = en_c;
            reg_rdata[BIT_RSV] = rsv;
        end
    end

    assign pa_disable = hot_q;
    assign irq_n      = ~((tflag & en_t) | (cflag & en_c));
endmodule

// File: rtl/ovld_checker.sv
module ovld_checker #(
    parameter int TEMP_W  = 8,
    parameter int TRIP_HI = 165,
    parameter int TRIP_LO = 145
) (
    input logic              clk,
    input logic              rst_n,
    input logic [TEMP_W-1:0] temp_code,
    input logic              pa_disable,
    input logic              irq_n,
    input logic              reg_wr,
    input logic              reg_sel,
    input logic [7:0]        reg_wdata,
    input logic              en_t,
    input logic              tflag
);
    assert_trip_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pa_disable) |-> ($past(temp_code) > TEMP_W'(TRIP_HI)));

    assert_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pa_disable) |-> ($past(temp_code) <= TEMP_W'(TRIP_LO)));

    assert_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tflag && !en_t) |=> !tflag);

    assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tflag && !(reg_wr && reg_sel && !reg_wdata[5])) |=> tflag);

    assert_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tflag && en_t) |-> !irq_n);
endmodule

bind ovld_supervisor ovld_checker #(.TEMP_W(TEMP_W), .TRIP_HI(TRIP_HI), .TRIP_LO(TRIP_LO)) i_chk (
    .clk(clk), .rst_n(rst_n), .temp_code(temp_code), .pa_disable(pa_disable),
    .irq_n(irq_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .en_t(en_t), .tflag(tflag)
);

// File: tb/test_ovld_supervisor.sv
module test_ovld_supervisor;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] temp_code = 8'd0;
    logic       ocp_in = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_sel = 1'b0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       pa_disable, irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit shut_m = 0;

    always #5 clk = ~clk;

    ovld_supervisor i_ovld_supervisor (
        .clk(clk), .rst_n(rst_n), .temp_code(temp_code), .ocp_in(ocp_in),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .pa_disable(pa_disable), .irq_n(irq_n)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic rd(input logic sel, output logic [7:0] v);
        reg_sel = sel;
        #1;
        v = reg_rdata;
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // apply a temperature, advance one edge, update the arithmetic model
    task automatic temp_step(input int t);
        temp_code = 8'(t);
        @(negedge clk);
        if (t > 165) shut_m = 1;
        else if (t <= 145) shut_m = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 reset state
        check("R8 disable", pa_disable, 0);
        check("R8 irq_n", irq_n, 1);
        rd(1'b0, v); check("R8 control", v, 0);
        rd(1'b1, v); check("R8 status", v, 0);

        // R1 R2 R3: full sweeps with all enables 0, flag unchanged (R4)
        for (int t = 0; t < 256; t++) begin
            temp_step(t);
            check("R1 up sweep", pa_disable, shut_m);
        end
        for (int t = 255; t >= 0; t--) begin
            temp_step(t);
            check("R2 down sweep", pa_disable, shut_m);
            rd(1'b1, v); check("R4 flag held while disabled", v, 0);
            check("R6 no irq when disabled", irq_n, 1);
        end
        for (int t = 140; t <= 170; t++) begin
            temp_step(t);
            check("R3 band climb", pa_disable, shut_m);
        end
        for (int t = 170; t >= 140; t--) begin
            temp_step(t);
            check("R3 band fall", pa_disable, shut_m);
        end

        // R10 control readback (bit 7 stored too)
        wr(1'b0, 8'hFF);
        rd(1'b0, v); check("R10 control all", v, 8'hE0);
        wr(1'b0, 8'h00);
        rd(1'b0, v); check("R10 control zero", v, 0);
        wr(1'b0, 8'h20);
        rd(1'b0, v); check("R10 thermal enable", v, 8'h20);

        // R4 thermal flag with enable, boundary 165 no trip
        temp_step(165);
        check("R1 165 no trip", pa_disable, 0);
        rd(1'b1, v); check("R4 no flag at 165", v, 0);
        temp_step(166);
        check("R1 166 trips", pa_disable, 1);
        rd(1'b1, v); check("R4 flag set", v, 8'h20);
        check("R6 irq low", irq_n, 0);
        temp_step(146);
        check("R2 146 holds", pa_disable, 1);
        temp_step(145);
        check("R2 145 releases", pa_disable, 0);
        repeat (4) @(negedge clk);
        rd(1'b1, v); check("R5 sticky after recovery", v, 8'h20);
        check("R5 irq still low", irq_n, 0);

        // R7 write-1 no effect, write-0 clears
        wr(1'b1, 8'hFF);
        rd(1'b1, v); check("R7 write one keeps", v, 8'h20);
        wr(1'b1, 8'h00);
        rd(1'b1, v); check("R7 write zero clears", v, 0);
        check("R7 irq released", irq_n, 1);

        // R7 set wins: overheat and clear on same edge
        temp_code = 8'd200;
        wr(1'b1, 8'h00);
        shut_m = 1;
        rd(1'b1, v); check("R7 set wins thermal", v, 8'h20);
        temp_step(100);

        // R6 enable removed: flag remains, irq high
        wr(1'b0, 8'h00);
        rd(1'b1, v); check("R6 flag kept", v, 8'h20);
        check("R6 irq high when enable off", irq_n, 1);
        wr(1'b1, 8'h00);

        // R9 current flag disabled: no set
        ocp_in = 1'b1;
        repeat (5) @(negedge clk);
        rd(1'b1, v); check("R9 current disabled", v, 0);
        ocp_in = 1'b0;
        repeat (4) @(negedge clk);

        // R9 latency with enable
        wr(1'b0, 8'h40);
        ocp_in = 1'b1;
        @(negedge clk); @(negedge clk);
        rd(1'b1, v); check("R9 not yet after two edges", v, 0);
        @(negedge clk);
        rd(1'b1, v); check("R9 set on third edge", v, 8'h40);
        check("R6 irq from current", irq_n, 0);
        wr(1'b1, 8'h00);
        repeat (4) @(negedge clk);
        rd(1'b1, v); check("R9 held level sets once", v, 0);
        check("R6 irq released", irq_n, 1);

        // R7 set wins for current flag
        ocp_in = 1'b0;
        repeat (4) @(negedge clk);
        ocp_in = 1'b1;
        @(negedge clk); @(negedge clk);
        wr(1'b1, 8'h00);
        rd(1'b1, v); check("R7 set wins current", v, 8'h40);

        // R3 thermal trips with only current enabled, no thermal flag
        temp_step(250);
        check("R3 trips enable-independent", pa_disable, 1);
        rd(1'b1, v); check("R4 thermal flag untouched", v, 8'h40);
        temp_step(0);
        check("R2 released", pa_disable, 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule